// File: doc/BRIEF.md
# Shift and Rotate Execution Unit

This unit carries out the shift and rotate operations of a processor's integer datapath. It takes a 16-bit instruction word, one operand and, when the count is held in a register, the value of that register. From these it produces the shifted or rotated result and the five condition flags: extend, negative, zero, overflow and carry. Four operations are supported: arithmetic shift, logical shift, rotate through the extend flag, and plain rotate. Each can run left or right, on a byte, word or long lane.

Memory access and the register file sit outside the unit. The surrounding pipeline fetches the operand, presents it with `in_valid`, and writes back the result one clock later. Bits of the operand outside the selected lane pass through unchanged, so the caller can write the full 32-bit value back.

In the memory form, the unit always shifts a single 16-bit word by exactly one position.

Top module: `shrot_unit`

## Requirements
- R1: Opcode bit 8 selects the direction: 1 shifts left, 0 shifts right.
- R2: In the register form, opcode bits 4:3 select the operation: 0 arithmetic shift, 1 logical shift, 2 rotate through extend, 3 plain rotate. An arithmetic right shift fills with the sign bit. A logical shift fills with zero.
- R3: When opcode bit 5 is 0, the count is taken from opcode bits 11:9, and the value 0 in that field means a count of 8.
- R4: When opcode bit 5 is 1, the count is `count_reg` modulo 64. A count larger than the lane width is still applied step by step.
- R5: When opcode bits 7:6 equal 3, the memory form applies. It works on a 16-bit word with a count of exactly one, takes the operation from opcode bits 10:9, and ignores opcode bits 5 and 11.
- R6: In the register form, opcode bits 7:6 select the lane: 0 byte (bits 7:0), 1 word (bits 15:0), 2 long (bits 31:0). Result bits above the lane equal the operand's bits.
- R7: For a nonzero count, carry equals the last bit shifted out. Extend takes the same value, except under plain rotate, where extend keeps `x_in`.
- R8: For a zero count, carry is 0 and extend keeps `x_in`. Under rotate through extend, carry instead equals `x_in`.
- R9: Overflow is 1 only for an arithmetic left shift in which the lane's top bit changed at any step. Every other case gives 0.
- R10: Negative equals the top bit of the lane result, and zero is 1 exactly when the lane result is all zero.
- R11: Results and flags are registered. They appear with `out_valid` one clock after `in_valid`, and reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation presented this cycle |
| opcode | input | 16 | Instruction word |
| operand | input | 32 | Value to shift (memory form: low 16 bits) |
| count_reg | input | 32 | Value of the count register for register-count forms |
| x_in | input | 1 | Current extend flag |
| out_valid | output | 1 | Result and flags valid |
| result | output | 32 | Operand with the selected lane replaced |
| flag_x | output | 1 | Extend |
| flag_n | output | 1 | Negative |
| flag_z | output | 1 | Zero |
| flag_v | output | 1 | Overflow |
| flag_c | output | 1 | Carry |

## Verification
The hardest case to reach is an arithmetic left shift in which the lane's top bit flips and then flips back. Here the final sign matches the original, yet overflow must still be reported. The stimulus reaches it with byte operands such as 0x50 shifted by two or more steps.

Register counts from 32 to 127 test the modulo-64 wrap. They also cover the case where every operand bit has been shifted out, and the case of an exactly zero count under rotate through extend.

A reference model in the bench is compared against the outputs on every clock. It handles directed vectors and several hundred pseudo-random ones, including back-to-back operations.

// File: rtl/shrot_pkg.sv
// Shared types and widths for the shift/rotate unit.
package shrot_pkg;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef enum logic [1:0] {
        OP_ARITH = 2'd0,
        OP_LOGIC = 2'd1,
        OP_ROTX  = 2'd2,
        OP_ROT   = 2'd3
    } shop_e;

    typedef enum logic [1:0] {
        LANE_B = 2'd0,
        LANE_W = 2'd1,
        LANE_L = 2'd2
    } lane_e;
endpackage

// File: rtl/shrot_decode.sv
// Field decoder: turns the instruction word and the count register into
// operation, direction, lane and step count.
// Assumes the caller only presents shift/rotate instruction words.
module shrot_decode
    import shrot_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic [15:0]     opcode,
    input  logic [31:0]     count_reg,
    output shop_e           op,
    output logic            left,
    output lane_e           lane,
    output logic [CW-1:0]   count,
    output logic            mem_form
);
    localparam logic [CW-1:0] IMM_EIGHT = CW'(8);

    // Purpose: pick form, operation, lane and count from the fields.
    always_comb begin
        mem_form = (opcode[7:6] == 2'b11);
        left     = opcode[8];
        if (mem_form) begin
            op    = shop_e'(opcode[10:9]);
            lane  = LANE_W;
            count = CW'(1);
        end else begin
            op   = shop_e'(opcode[4:3]);
            lane = lane_e'(opcode[7:6]);
            if (opcode[5])
                count = count_reg[CW-1:0];
            else if (opcode[11:9] == 3'd0)
                count = IMM_EIGHT;
            else
                count = CW'(opcode[11:9]);
        end
    end

    // Purpose: an immediate count never decodes to zero or above eight.
    always_comb begin
        if (!mem_form && !opcode[5])
            assert_imm_count_R3: assert (count >= CW'(1) && count <= IMM_EIGHT);
    end
endmodule

// File: rtl/shrot_core.sv
// Combinational shifter: applies the decoded operation one bit per step
// for up to 2**CW-1 steps on the selected lane and derives the flags.
// Assumes lane is never the reserved encoding 3.
module shrot_core
    import shrot_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  shop_e           op,
    input  logic            left,
    input  lane_e           lane,
    input  logic [CW-1:0]   count,
    input  logic [DW-1:0]   operand,
    input  logic            x_in,
    output logic [DW-1:0]   result,
    output logic            x_out,
    output logic            n_out,
    output logic            z_out,
    output logic            v_out,
    output logic            c_out
);
    localparam int MAX_STEPS = 1 << CW;

    logic [DW-1:0] mask;
    logic [4:0]    top;

    // Purpose: lane mask and index of the lane's top bit.
    always_comb begin
        case (lane)
            LANE_B:  begin mask = DW'(8'hFF);   top = 5'd7;  end
            LANE_W:  begin mask = DW'(16'hFFFF); top = 5'd15; end
            default: begin mask = '1;            top = 5'(DW-1); end
        endcase
    end

    logic [DW-1:0] v;
    logic          xs, last, ovf, fill;

    // Purpose: step the lane value count times, tracking shifted-out bits.
    always_comb begin
        v    = operand & mask;
        xs   = x_in;
        last = 1'b0;
        ovf  = 1'b0;
        fill = 1'b0;
        for (int i = 0; i < MAX_STEPS; i++) begin
            if (CW'(i) < count) begin
                if (left) begin
                    last = v[top];
                    case (op)
                        OP_ROTX: fill = xs;
                        OP_ROT:  fill = v[top];
                        default: fill = 1'b0;
                    endcase
                    v = ((v << 1) | DW'(fill)) & mask;
                    if (op == OP_ARITH && v[top] != last)
                        ovf = 1'b1;
                end else begin
                    last = v[0];
                    case (op)
                        OP_ARITH: fill = v[top];
                        OP_ROTX:  fill = xs;
                        OP_ROT:   fill = v[0];
                        default:  fill = 1'b0;
                    endcase
                    v = (v >> 1) | (DW'(fill) << top);
                end
                if (op == OP_ROTX)
                    xs = last;
            end
        end
    end

    // Purpose: merge the lane into the operand and form the flags.
    always_comb begin
        result = (operand & ~mask) | v;
        n_out  = v[top];
        z_out  = (v == '0);
        v_out  = ovf;
        if (count == '0) begin
            c_out = (op == OP_ROTX) ? x_in : 1'b0;
            x_out = x_in;
        end else begin
            c_out = last;
            x_out = (op == OP_ROT) ? x_in : last;
        end
    end
endmodule

// File: rtl/shrot_unit.sv
// Shift/rotate execution unit top: decode, compute, then one output
// register stage with a valid bit. Synchronous active-low reset.
// Assumes the operand and count register are stable alongside in_valid.
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [15:0]   opcode,
    input  logic [DW-1:0] operand,
    input  logic [31:0]   count_reg,
    input  logic          x_in,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic          flag_x,
    output logic          flag_n,
    output logic          flag_z,
    output logic          flag_v,
    output logic          flag_c
);
    shop_e         d_op;
    lane_e         d_lane;
    logic          d_left, d_mem;
    logic [CW-1:0] d_count;
    logic [DW-1:0] c_res;
    logic          c_x, c_n, c_z, c_v, c_c;

    shrot_decode #(.CW(CW)) u_dec (
        .opcode(opcode), .count_reg(count_reg), .op(d_op), .left(d_left),
        .lane(d_lane), .count(d_count), .mem_form(d_mem)
    );

    shrot_core #(.DW(DW), .CW(CW)) u_core (
        .op(d_op), .left(d_left), .lane(d_lane), .count(d_count),
        .operand(operand), .x_in(x_in), .result(c_res), .x_out(c_x),
        .n_out(c_n), .z_out(c_z), .v_out(c_v), .c_out(c_c)
    );

    // Purpose: register result and flags for one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_x    <= 1'b0;
            flag_n    <= 1'b0;
            flag_z    <= 1'b0;
            flag_v    <= 1'b0;
            flag_c    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= c_res;
                flag_x <= c_x;
                flag_n <= c_n;
                flag_z <= c_z;
                flag_v <= c_v;
                flag_c <= c_c;
            end
        end
    end

    assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_v_only_asl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !(d_op == OP_ARITH && d_left)) |=> !flag_v);
    assert_rot_keeps_x_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_op == OP_ROT) |=> (flag_x == $past(x_in)));
    assert_zero_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_count == '0 && d_op != OP_ROTX) |=> !flag_c);
    assert_byte_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !d_mem && d_lane == LANE_B) |=> (result[DW-1:8] == $past(operand[DW-1:8])));
    assert_word_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && d_mem) |=> (result[DW-1:16] == $past(operand[DW-1:16])));
endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] opcode = '0;
    logic [31:0] operand = '0;
    logic [31:0] count_reg = '0;
    logic        x_in = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    shrot_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .operand(operand), .count_reg(count_reg), .x_in(x_in),
        .out_valid(out_valid), .result(result), .flag_x(flag_x),
        .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
    );

    // Expected output of the previous cycle: {valid, result, x, n, z, v, c}
    logic [37:0] pend = '0;
    string       pend_tag = "R11";

    function automatic logic [15:0] reg_op(int f, bit lft, int sz, bit rc, int kind);
        return {4'hE, 3'(f), lft, 2'(sz), rc, 2'(kind), 3'b000};
    endfunction

    function automatic logic [15:0] mem_op(int kind, bit lft);
        return {4'hE, 1'b0, 2'(kind), lft, 2'b11, 6'b000000};
    endfunction

    function automatic logic [36:0] model(logic [15:0] opc, logic [31:0] opd,
                                          logic [31:0] creg, logic xi);
        int w, cnt, kind;
        logic [31:0] m, v;
        bit c, x, ov, o, f;
        if (opc[7:6] == 2'b11) begin
            w = 16; cnt = 1; kind = int'(opc[10:9]);
        end else begin
            w = 8 << opc[7:6];
            kind = int'(opc[4:3]);
            cnt = opc[5] ? int'(creg % 64) : (opc[11:9] == 0 ? 8 : int'(opc[11:9]));
        end
        m = (w == 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 1);
        v = opd & m; x = xi; ov = 0; o = 0;
        for (int i = 0; i < cnt; i++) begin
            if (opc[8]) begin
                o = v[w-1];
                f = (kind == 2) ? x : (kind == 3) ? o : 1'b0;
                v = ((v << 1) | 32'(f)) & m;
                if (kind == 0 && v[w-1] != o) ov = 1;
            end else begin
                o = v[0];
                f = (kind == 0) ? v[w-1] : (kind == 2) ? x : (kind == 3) ? o : 1'b0;
                v = (v >> 1) | (32'(f) << (w - 1));
            end
            if (kind == 2) x = o;
        end
        if (cnt == 0) begin
            c = (kind == 2) ? xi : 1'b0; x = xi;
        end else begin
            c = o; x = (kind == 3) ? xi : o;
        end
        return {(opd & ~m) | v, x, v[w-1], v == 0, ov, c};
    endfunction

    task automatic compare();
        logic [37:0] got;
        got = {out_valid, result, flag_x, flag_n, flag_z, flag_v, flag_c};
        checks++;
        if (got !== pend) begin
            fails++;
            $display("FAIL %s: got v=%0b res=%h xnzvc=%b expected v=%0b res=%h xnzvc=%b",
                     pend_tag, got[37], got[36:5], got[4:0], pend[37], pend[36:5], pend[4:0]);
        end
    endtask

    // Drive one cycle (vld=0 for idle) and check the previous cycle's output.
    task automatic step(bit vld, logic [15:0] opc, logic [31:0] opd,
                        logic [31:0] creg, logic xi, string tag);
        @(negedge clk);
        compare();
        in_valid = vld; opcode = opc; operand = opd; count_reg = creg; x_in = xi;
        if (vld) pend = {1'b1, model(opc, opd, creg, xi)};
        else     pend = {1'b0, pend[36:0]};
        pend_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R11: reset state, all outputs zero
        step(0, 0, 0, 0, 0, "R11");
        rst_n = 1'b1;
        step(0, 0, 0, 0, 0, "R11");
        // R1, R2: left/right for each operation on a word
        for (int k = 0; k < 4; k++) begin
            step(1, reg_op(3, 1, 1, 0, k), 32'h1234_C00F, 0, 1, "R2 left");
            step(1, reg_op(3, 0, 1, 0, k), 32'h1234_C00F, 0, 0, "R1 right");
        end
        // R3: immediate field 0 means 8
        step(1, reg_op(0, 1, 2, 0, 1), 32'h8765_4321, 0, 0, "R3");
        step(1, reg_op(0, 0, 0, 0, 3), 32'hAAAA_AA5A, 0, 0, "R3");
        // R4: register counts with wrap, zero and large
        step(1, reg_op(1, 1, 2, 1, 1), 32'h0000_0001, 65, 0, "R4");
        step(1, reg_op(1, 0, 2, 1, 0), 32'h8000_0000, 63, 0, "R4");
        step(1, reg_op(1, 1, 1, 1, 1), 32'hFFFF_8001, 40, 0, "R4");
        // R8: zero count per operation
        step(1, reg_op(1, 1, 0, 1, 2), 32'h0000_0080, 64, 1, "R8");
        step(1, reg_op(1, 1, 0, 1, 0), 32'h0000_0080, 0, 1, "R8");
        step(1, reg_op(1, 0, 1, 1, 3), 32'h0000_0000, 128, 0, "R8");
        // R9: sign flips then flips back, plus plain cases
        step(1, reg_op(2, 1, 0, 0, 0), 32'h0000_0050, 0, 0, "R9");
        step(1, reg_op(1, 1, 0, 0, 0), 32'h0000_0040, 0, 0, "R9");
        step(1, reg_op(1, 1, 0, 0, 1), 32'h0000_0040, 0, 0, "R9");
        // R5: memory form with bits 5 and 11 set to be ignored
        for (int k = 0; k < 4; k++) begin
            step(1, mem_op(k, 1) | 16'h0820, 32'hDEAD_8001, 5, 1, "R5");
            step(1, mem_op(k, 0), 32'hDEAD_8001, 0, 0, "R5");
        end
        // R6, R10: lanes preserved, zero and negative flags
        step(1, reg_op(1, 0, 0, 0, 1), 32'hFFFF_FF01, 0, 0, "R10");
        step(1, reg_op(4, 1, 0, 0, 1), 32'h1234_5608, 0, 0, "R6");
        step(0, 0, 0, 0, 0, "R11");
        // R7 and general: pseudo-random coverage
        for (int i = 0; i < 600; i++) begin
            logic [15:0] o;
            logic [31:0] r;
            r = $urandom;
            if (r[2:0] == 0) o = mem_op(int'(r[4:3]), r[5]);
            else o = reg_op(int'(r[8:6]), r[9], int'(r[11:10]) % 3, r[12], int'(r[14:13]));
            step(r[15] | r[16], o, $urandom, $urandom % 130, r[17], "R7");
        end
        step(0, 0, 0, 0, 0, "R11");
        step(0, 0, 0, 0, 0, "R11");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule